// File: doc/BRIEF.md
# Secondary Core Release Table

A memory-mapped table of boot-release records, one per processor core, through which the primary core wakes up the secondary cores. Each record is 32 bytes wide. It holds a 64-bit entry address, a 64-bit boot argument, a 32-bit processor identifier and two reserved areas. A simple bus slave reads and writes the table in big-endian byte order, with 1-, 2- or 4-byte accesses at any byte offset. Every access completes in one cycle, and read data is registered.

A secondary core stays parked while bit 0 of its entry address is 1. Any accepted write that leaves that bit at 0 releases the core. In the next cycle the block pulses that core's bit of a start vector. In the same cycle it drives a shared parameter bus with the following values:

- the start program counter;
- the boot register values for registers r3 to r9;
- a translation-entry descriptor that maps a 64 MiB window at virtual address 0 onto the block of memory that holds the entry address.

Top module: `core_release_table`

## Requirements
- R1: After reset, record i of every present core reads back entry address 1, argument i and processor ID i, with all other bytes 0. Record layout: entry address at bytes 0-7, argument at bytes 8-15, processor ID at bytes 20-23, and reserved bytes elsewhere.
- R2: Multi-byte values are big-endian on the bus. The byte at the lowest address is the most significant byte of the right-justified data.
- R3: `size_i` selects 1 byte (0), 2 bytes (1) or 4 bytes (2). Code 3 writes nothing and reads back 0. Accesses may start at any byte offset.
- R4: Writes to records that have no present core are discarded. Reads of bytes at or beyond `NUM_CORES*32` return 0.
- R5: Writes to record 0 (the primary core) are discarded, and core 0 never receives a start.
- R6: The start strobe is raised after every accepted write that leaves the record's entry bit 0 at 0. This holds even when the write touched another field. It is a one-cycle pulse, in the cycle after the write, on that core's bit only.
- R7: An accepted write that leaves entry bit 0 at 1 raises no start.
- R8: On start, `pc_o` is the entry address modulo 2^WIN_LOG2 (64 MiB by default), and `tlb_pa_o` is the entry address rounded down to that boundary.
- R9: On start, boot register r3 carries the record's argument and r7 carries 2^WIN_LOG2. Registers r4, r5, r6, r8 and r9 are 0. `boot_regs_o` slot j (bits 64j+63:64j) holds register r(3+j).
- R10: On release, the record's processor ID field is set to the core index. This overrides bytes written to it in the same access.
- R11: On start, `tlb_va_o` is 0 and `tlb_size_o` is (WIN_LOG2-10)/2, which is 8 for 64 MiB. `tlb_flags_o` is 8'hFF: bit 7 valid, bit 6 coherent, bits 5:0 user and supervisor read/write/execute.
- R12: When a write runs past the end of its record, the bytes beyond the end are dropped. A read that crosses a record boundary continues into the next record.
- R13: `rdata_o` is updated in the clock cycle after a read request and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write request |
| rd_en_i | input | 1 | Read request |
| addr_i | input | AW (10) | Byte address within the window |
| size_i | input | 2 | Access size code |
| wdata_i | input | 32 | Right-justified write data |
| rdata_o | output | 32 | Right-justified read data, registered |
| start_o | output | NUM_CORES | One-cycle start strobe per core |
| pc_o | output | 64 | Start program counter |
| boot_regs_o | output | 448 | Boot registers r3..r9, one 64-bit slot each |
| tlb_va_o | output | 64 | Descriptor virtual base |
| tlb_pa_o | output | 64 | Descriptor physical base |
| tlb_size_o | output | 4 | Descriptor size code |
| tlb_flags_o | output | 8 | Descriptor valid, coherent and permission bits |

## Verification
The following are checked by assertions on every cycle:

- the start vector is one-hot or idle;
- core 0 is never started;
- a start never appears without a write in the previous cycle;
- the started core's stored entry address is rebuilt exactly from the window base and PC;
- the processor ID is stamped after every release;
- the descriptor carries full rights and the right size.

Only the bench scenarios can show the rest. This covers big-endian lane ordering for every size and unaligned offset, dropped spill bytes, discarded writes to record 0 and absent records, the held-versus-released decision for each write, and the argument and identifier values carried by each start.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int REC_BYTES  = 32;
  localparam int REC_SHIFT  = 5;
  localparam int ENTRY_OFF  = 0;
  localparam int ARG_OFF    = 8;
  localparam int PID_OFF    = 20;
  localparam int BOOT_SLOTS = 7;   // registers r3..r9
  localparam int SLOT_ARG   = 0;   // r3
  localparam int SLOT_WIN   = 4;   // r7
  localparam int MAX_LANES  = 4;

  localparam logic [7:0] TLB_FULL_FLAGS = 8'hFF;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_NONE = 2'd3
  } acc_size_e;

  function automatic int acc_bytes(logic [1:0] sz);
    case (acc_size_e'(sz))
      ACC_BYTE: return 1;
      ACC_HALF: return 2;
      ACC_WORD: return 4;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [3:0] tlb_size_code(int win_log2);
    return 4'((win_log2 - 10) / 2);
  endfunction
endpackage

// File: rtl/crt_wr_decode.sv
module crt_wr_decode
  import crt_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int AW        = 10
) (
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [1:0]               size_i,
  input  logic [31:0]              wdata_i,
  output logic [NUM_CORES-1:0]     hit_o,
  output logic [REC_BYTES-1:0]     be_o,
  output logic [8*REC_BYTES-1:0]   data_o
);
  localparam int IW = AW - REC_SHIFT;

  logic [IW-1:0]        rec_idx;
  logic [REC_SHIFT-1:0] rec_off;
  int                   nbytes;

  assign rec_idx = addr_i[AW-1:REC_SHIFT];
  assign rec_off = addr_i[REC_SHIFT-1:0];

  // Spread the right-justified bus data onto record byte lanes, MSB first;
  // lanes that fall past the record end are dropped (R12).
  always_comb begin
    nbytes = acc_bytes(size_i);
    be_o   = '0;
    data_o = '0;
    for (int k = 0; k < MAX_LANES; k++) begin
      if (k < nbytes && (int'(rec_off) + k) < REC_BYTES) begin
        be_o[int'(rec_off) + k]            = 1'b1;
        data_o[8*(int'(rec_off) + k) +: 8] = 8'(wdata_i >> (8 * (nbytes - 1 - k)));
      end
    end
  end

  // Record 0 (primary) and absent records never accept writes (R4, R5).
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_hit
    if (c == 0) begin : g_primary
      assign hit_o[c] = 1'b0;
    end else begin : g_secondary
      assign hit_o[c] = wr_en_i && (nbytes != 0) && (rec_idx == IW'(c));
    end
  end
endmodule

// File: rtl/crt_record.sv
module crt_record
  import crt_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_hit_i,
  input  logic [REC_BYTES-1:0]    be_i,
  input  logic [8*REC_BYTES-1:0]  data_i,
  output logic [8*REC_BYTES-1:0]  rec_o,
  output logic [63:0]             entry_nxt_o,
  output logic [63:0]             arg_nxt_o,
  output logic                    release_o
);
  logic [7:0] mem_q [REC_BYTES];
  logic [7:0] nxt   [REC_BYTES];

  // Reset image: entry = 1 (held), argument = IDX, processor ID = IDX (R1).
  function automatic logic [7:0] init_byte(int b);
    logic [63:0] id64;
    id64 = 64'(IDX);
    if (b == ENTRY_OFF + 7)                    return 8'h01;
    if (b >= ARG_OFF && b < ARG_OFF + 8)       return id64[8*(ARG_OFF + 7 - b) +: 8];
    if (b >= PID_OFF && b < PID_OFF + 4)       return id64[8*(PID_OFF + 3 - b) +: 8];
    return 8'h00;
  endfunction

  always_comb begin
    for (int b = 0; b < REC_BYTES; b++) begin
      nxt[b] = (wr_hit_i && be_i[b]) ? data_i[8*b +: 8] : mem_q[b];
    end
  end

  // Post-write entry and argument, big-endian assembled.
  always_comb begin
    for (int b = 0; b < 8; b++) begin
      entry_nxt_o[8*(7-b) +: 8] = nxt[ENTRY_OFF + b];
      arg_nxt_o[8*(7-b) +: 8]   = nxt[ARG_OFF + b];
    end
  end

  assign release_o = wr_hit_i && !entry_nxt_o[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < REC_BYTES; b++) mem_q[b] <= init_byte(b);
    end else if (wr_hit_i) begin
      for (int b = 0; b < REC_BYTES; b++) begin
        if (release_o && b >= PID_OFF && b < PID_OFF + 4)
          mem_q[b] <= init_byte(b);   // stamp own ID, overrides written bytes (R10)
        else
          mem_q[b] <= nxt[b];
      end
    end
  end

  for (genvar b = 0; b < REC_BYTES; b++) begin : g_flat
    assign rec_o[8*b +: 8] = mem_q[b];
  end

  // R10: after a release the ID field holds the core index.
  a_r10_pid_stamped: assert property (@(posedge clk) disable iff (rst)
    release_o |=> {mem_q[PID_OFF], mem_q[PID_OFF+1], mem_q[PID_OFF+2], mem_q[PID_OFF+3]} == 32'(IDX))
    else $error("a_r10_pid_stamped");
endmodule

// File: rtl/crt_rd_mux.sv
module crt_rd_mux
  import crt_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int AW        = 10
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd_en_i,
  input  logic [AW-1:0]                     addr_i,
  input  logic [1:0]                        size_i,
  input  logic [NUM_CORES*8*REC_BYTES-1:0]  recs_i,
  output logic [31:0]                       rdata_o
);
  localparam int POP_BYTES = NUM_CORES * REC_BYTES;

  logic [31:0] rd_d;
  int          nbytes;
  int          a;

  // Gather bytes across record boundaries; unpopulated bytes read 0 (R4, R12).
  always_comb begin
    nbytes = acc_bytes(size_i);
    rd_d   = '0;
    a      = 0;
    for (int k = 0; k < MAX_LANES; k++) begin
      a = int'(addr_i) + k;
      if (k < nbytes && a < POP_BYTES) begin
        rd_d = rd_d | (32'(recs_i[8*a +: 8]) << (8 * (nbytes - 1 - k)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_d;
  end
endmodule

// File: rtl/crt_launch.sv
module crt_launch
  import crt_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int WIN_LOG2  = 26
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CORES-1:0]        rel_i,
  input  logic [NUM_CORES*64-1:0]     entries_i,
  input  logic [NUM_CORES*64-1:0]     args_i,
  output logic [NUM_CORES-1:0]        start_o,
  output logic [63:0]                 pc_o,
  output logic [BOOT_SLOTS*64-1:0]    boot_regs_o,
  output logic [63:0]                 tlb_va_o,
  output logic [63:0]                 tlb_pa_o,
  output logic [3:0]                  tlb_size_o,
  output logic [7:0]                  tlb_flags_o
);
  localparam logic [63:0] WIN_SIZE = 64'(1) << WIN_LOG2;
  localparam logic [63:0] WIN_MASK = WIN_SIZE - 64'd1;
  localparam logic [3:0]  SZ_CODE  = tlb_size_code(WIN_LOG2);

  logic [63:0]              sel_entry, sel_arg;
  logic [BOOT_SLOTS*64-1:0] regs_d;

  always_comb begin
    sel_entry = '0;
    sel_arg   = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (rel_i[c]) begin
        sel_entry = sel_entry | entries_i[64*c +: 64];
        sel_arg   = sel_arg   | args_i[64*c +: 64];
      end
    end
    regs_d                    = '0;
    regs_d[64*SLOT_ARG +: 64] = sel_arg;
    regs_d[64*SLOT_WIN +: 64] = WIN_SIZE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o     <= '0;
      pc_o        <= '0;
      boot_regs_o <= '0;
      tlb_pa_o    <= '0;
      tlb_size_o  <= '0;
      tlb_flags_o <= '0;
    end else begin
      start_o <= rel_i;
      if (|rel_i) begin
        pc_o        <= sel_entry & WIN_MASK;
        tlb_pa_o    <= sel_entry & ~WIN_MASK;
        boot_regs_o <= regs_d;
        tlb_size_o  <= SZ_CODE;
        tlb_flags_o <= TLB_FULL_FLAGS;
      end
    end
  end

  assign tlb_va_o = '0;

  // R11: every start presents a full-rights descriptor of the window size.
  a_r11_descriptor_on_start: assert property (@(posedge clk) disable iff (rst)
    (|start_o) |-> (tlb_flags_o == 8'hFF && tlb_size_o == SZ_CODE && tlb_va_o == '0))
    else $error("a_r11_descriptor_on_start");
endmodule

// File: rtl/core_release_table.sv
module core_release_table
  import crt_pkg::*;
#(
  parameter int MAX_REC   = 32,
  parameter int NUM_CORES = 4,
  parameter int WIN_LOG2  = 26,
  localparam int AW       = $clog2(MAX_REC * REC_BYTES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [1:0]                 size_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rdata_o,
  output logic [NUM_CORES-1:0]       start_o,
  output logic [63:0]                pc_o,
  output logic [BOOT_SLOTS*64-1:0]   boot_regs_o,
  output logic [63:0]                tlb_va_o,
  output logic [63:0]                tlb_pa_o,
  output logic [3:0]                 tlb_size_o,
  output logic [7:0]                 tlb_flags_o
);
  localparam int RW = 8 * REC_BYTES;

  logic [NUM_CORES-1:0]    hit, rel;
  logic [REC_BYTES-1:0]    be;
  logic [RW-1:0]           wbytes;
  logic [NUM_CORES*RW-1:0] recs;
  logic [NUM_CORES*64-1:0] entries_nxt, args_nxt;
  logic [63:0]             entry_q [NUM_CORES];

  crt_wr_decode #(.NUM_CORES(NUM_CORES), .AW(AW)) i_dec (
    .wr_en_i(wr_en_i), .addr_i(addr_i), .size_i(size_i), .wdata_i(wdata_i),
    .hit_o(hit), .be_o(be), .data_o(wbytes)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_rec
    crt_record #(.IDX(c)) i_rec (
      .clk(clk), .rst(rst), .wr_hit_i(hit[c]), .be_i(be), .data_i(wbytes),
      .rec_o(recs[RW*c +: RW]),
      .entry_nxt_o(entries_nxt[64*c +: 64]),
      .arg_nxt_o(args_nxt[64*c +: 64]),
      .release_o(rel[c])
    );
    for (genvar b = 0; b < 8; b++) begin : g_eq
      assign entry_q[c][8*(7-b) +: 8] = recs[RW*c + 8*(ENTRY_OFF+b) +: 8];
    end

    // R8: window base and PC of a started core rebuild its stored entry.
    a_r8_window_split: assert property (@(posedge clk) disable iff (rst)
      start_o[c] |-> ((tlb_pa_o | pc_o) == entry_q[c]))
      else $error("a_r8_window_split");
  end

  crt_rd_mux #(.NUM_CORES(NUM_CORES), .AW(AW)) i_rd (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .addr_i(addr_i), .size_i(size_i),
    .recs_i(recs), .rdata_o(rdata_o)
  );

  crt_launch #(.NUM_CORES(NUM_CORES), .WIN_LOG2(WIN_LOG2)) i_launch (
    .clk(clk), .rst(rst), .rel_i(rel), .entries_i(entries_nxt), .args_i(args_nxt),
    .start_o(start_o), .pc_o(pc_o), .boot_regs_o(boot_regs_o),
    .tlb_va_o(tlb_va_o), .tlb_pa_o(tlb_pa_o), .tlb_size_o(tlb_size_o),
    .tlb_flags_o(tlb_flags_o)
  );

  // R6: a start is one core at a time and always follows a write.
  a_r6_single_core_start: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_o)) else $error("a_r6_single_core_start");
  a_r6_start_after_write: assert property (@(posedge clk) disable iff (rst)
    (start_o != '0) |-> $past(wr_en_i)) else $error("a_r6_start_after_write");
  // R5: the primary core is never started.
  a_r5_primary_idle: assert property (@(posedge clk) disable iff (rst)
    !start_o[0]) else $error("a_r5_primary_idle");
endmodule

// File: tb/test_core_release_table.sv
module test_core_release_table;
  localparam int NC = 4;
  localparam logic [63:0] WIN = 64'h0000_0000_0400_0000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]        addr = '0;
  logic [1:0]        size = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NC-1:0]     start;
  logic [63:0]       pc, tva, tpa;
  logic [7*64-1:0]   regs;
  logic [3:0]        tsz;
  logic [7:0]        tfl;

  always #4 clk = ~clk;  // 125 MHz

  core_release_table #(.NUM_CORES(NC)) i_core_release_table (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .start_o(start),
    .pc_o(pc), .boot_regs_o(regs), .tlb_va_o(tva), .tlb_pa_o(tpa),
    .tlb_size_o(tsz), .tlb_flags_o(tfl)
  );

  typedef struct {
    logic [NC-1:0] vec;
    logic [63:0]   entry;
    logic [63:0]   arg;
    string         req;
  } start_exp_t;

  start_exp_t  sq[$];
  logic [31:0] rq[$];
  string       rreq[$];
  logic [7:0]  model [1024];
  int          n_checks = 0, n_fail = 0;
  logic        wr_seen = 1'b0, rd_seen = 1'b0;

  function automatic void chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  function automatic int nb_of(logic [1:0] s);
    return (s == 2'd3) ? 0 : (1 << s);
  endfunction

  function automatic logic [63:0] model_field(int rec, int off, int len);
    logic [63:0] v = '0;
    for (int k = 0; k < len; k++) v = (v << 8) | 64'(model[rec*32 + off + k]);
    return v;
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 1024; a++) model[a] = 8'h00;
    for (int r = 0; r < NC; r++) begin
      model[r*32 + 7]  = 8'h01;
      model[r*32 + 15] = 8'(r);
      model[r*32 + 23] = 8'(r);
    end
  endtask

  task automatic do_write(int a, logic [1:0] s, logic [31:0] d, string req);
    start_exp_t e;
    int idx = a / 32;
    int nb  = nb_of(s);
    e.vec = '0; e.entry = '0; e.arg = '0; e.req = req;
    if (nb != 0 && idx != 0 && idx < NC) begin
      for (int k = 0; k < nb; k++) begin
        if ((a % 32) + k < 32) model[a + k] = 8'(d >> (8 * (nb - 1 - k)));
      end
      e.entry = model_field(idx, 0, 8);
      if (!e.entry[0]) begin
        e.vec = NC'(1) << idx;
        e.arg = model_field(idx, 8, 8);
        for (int k = 0; k < 4; k++) model[idx*32 + 20 + k] = 8'((idx) >> (8 * (3 - k)));
      end
    end
    sq.push_back(e);
    @(negedge clk);
    wr_en = 1'b1; addr = 10'(a); size = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(int a, logic [1:0] s, string req);
    logic [31:0] v = '0;
    int nb = nb_of(s);
    for (int k = 0; k < nb; k++) begin
      if (a + k < NC * 32) v = v | (32'(model[a + k]) << (8 * (nb - 1 - k)));
    end
    rq.push_back(v); rreq.push_back(req);
    @(negedge clk);
    rd_en = 1'b1; addr = 10'(a); size = s;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) begin
    wr_seen <= wr_en && !rst;
    rd_seen <= rd_en && !rst;
  end

  // Monitor: compare results one cycle after each request.
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_seen) begin
        start_exp_t e;
        e = sq.pop_front();
        chk(start == e.vec, {e.req, " start vector"}, 64'(start), 64'(e.vec));
        if (e.vec != '0) begin
          chk(pc == (e.entry & (WIN - 1)), "R8 pc", pc, e.entry & (WIN - 1));
          chk(tpa == (e.entry & ~(WIN - 1)), "R8 window base", tpa, e.entry & ~(WIN - 1));
          for (int j = 0; j < 7; j++) begin
            logic [63:0] ex;
            ex = (j == 0) ? e.arg : (j == 4) ? WIN : 64'd0;
            chk(regs[64*j +: 64] == ex, "R9 boot register", regs[64*j +: 64], ex);
          end
          chk(tva == 64'd0 && tsz == 4'd8 && tfl == 8'hFF, "R11 descriptor",
              {tva[31:0], 20'd0, tsz, tfl}, {32'd0, 20'd0, 4'd8, 8'hFF});
        end
      end else if (start != '0) begin
        chk(1'b0, "R6 unexpected start", 64'(start), 64'd0);
      end
      if (rd_seen) begin
        logic [31:0] ev;
        string r;
        ev = rq.pop_front(); r = rreq.pop_front();
        chk(rdata == ev, r, 64'(rdata), 64'(ev));
      end
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(start == '0 && rdata == '0, "R6 idle after reset", {start, rdata}, 64'd0);

    // R1 reset image
    do_read(36, 2'd2, "R1 entry low core1");
    do_read(32, 2'd2, "R1 entry high core1");
    do_read(84, 2'd2, "R1 pid core2");
    do_read(108, 2'd2, "R1 arg core3");
    do_read(20, 2'd2, "R1 pid core0");
    // R4 unpopulated reads
    do_read(4*32 + 20, 2'd2, "R4 absent record read");
    do_read(126, 2'd2, "R12 read spanning populated end");
    // R2 big-endian halfword
    do_write(48, 2'd1, 32'h0000_ABCD, "R7 reserved write held");
    do_read(48, 2'd0, "R2 byte msb");
    do_read(49, 2'd0, "R2 byte lsb");
    do_read(48, 2'd2, "R2 word view");
    // R12 spill dropped on write, read crosses records
    do_write(61, 2'd2, 32'h1122_3344, "R12 spill write held");
    do_read(60, 2'd2, "R12 tail bytes");
    do_read(64, 2'd0, "R12 next record untouched");
    // R5 primary write discarded
    do_write(4, 2'd2, 32'h0000_0000, "R5 primary write");
    do_read(4, 2'd2, "R5 primary entry unchanged");
    // R4 absent write discarded
    do_write(5*32 + 4, 2'd2, 32'h0000_0000, "R4 absent write");
    do_read(5*32 + 4, 2'd2, "R4 absent still zero");
    // R3 size code 3 ignored
    do_write(36, 2'd3, 32'h0, "R3 size3 write");
    do_read(36, 2'd2, "R3 entry intact after size3");
    do_read(36, 2'd3, "R3 size3 read zero");
    // R6/R8/R9 release of core2
    do_write(64, 2'd2, 32'h0000_0001, "R7 high word held");
    do_write(68, 2'd2, 32'h0C12_3456, "R6 release core2");
    // R10 pid override of core3
    do_write(116, 2'd2, 32'h0000_0055, "R7 pid write held");
    do_read(116, 2'd2, "R10 pid written while held");
    do_write(108, 2'd2, 32'h0000_0077, "R7 arg write held");
    do_write(103, 2'd0, 32'h0000_0000, "R6 release core3 by byte");
    do_read(116, 2'd2, "R10 pid stamped");
    do_write(116, 2'd2, 32'h0000_0099, "R10 pid write while released");
    do_read(116, 2'd2, "R10 pid overrides written bytes");
    do_write(112, 2'd2, 32'h0000_1234, "R6 repeated start on other field");
    // halfword + byte release of core1
    do_write(36, 2'd1, 32'h0000_0800, "R7 halfword held");
    do_write(39, 2'd0, 32'h0000_0010, "R6 release core1");
    do_read(36, 2'd2, "R13 entry low after release");
    do_read(0, 2'd1, "R13 read primary halfword");

    repeat (3) @(negedge clk);
    chk(sq.size() == 0 && rq.size() == 0, "R13 all results observed",
        64'(sq.size() + rq.size()), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R6 watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule